// File: doc/BRIEF.md
# Two-Channel High-Side Switch Protection and Diagnostic Controller

This block is the digital supervisor for a pair of high-side power switches. Each channel receives a logic on-request and a handful of comparator results from the analog front end: junction over-temperature, junction cooled to the restart point, current limiter engaged, load current under the on-state open-load threshold, and output voltage over the off-state threshold. Two supply flags, undervoltage and overvoltage, are common to both channels. From these the block drives one gate enable per channel and one status pull-down request per channel. The pull-down request drives an active-low open-drain status pin. When the request is 1 the pin is pulled low. When it is 0 the pin is released and reads high.

The encoding of the status pin depends on the fault. Thermal and on-state open-load faults pull the pin low only while the request is high. An off-state fault pulls it low only while the request is low. Supply faults never pull it low. A thermal event latches the gate off. The gate comes back by itself once the cooled flag is seen. Every reported fault must hold through its own filter window. The windows count a 1 µs tick produced by a clock prescaler, and a condition that drops before its window ends restarts the count.

Top module: `hsd_diag`

## Requirements
- R1: With no fault present, gateEn[c] equals inReq[c] in the same cycle and statPullDn[c] stays 0 for both request levels; gateEn[c] is never 1 while inReq[c] is 0.
- R2: otFlag[c] high at a clock edge forces gateEn[c] to 0 from that edge onward. The gate stays off after otFlag[c] falls, until the cooled flag trFlag[c] is seen.
- R3: While the thermal latch is set, a clock edge with trFlag[c]=1 and otFlag[c]=0 clears it, and gateEn[c] then follows inReq[c] again.
- R4: Once the thermal latch has been set for OVL_DLY_US ticks, statPullDn[c] is 1 whenever inReq[c] is 1 and 0 whenever inReq[c] is 0. It is 0 before the window ends.
- R5: uvFlag or ovFlag forces both gate enables to 0 in the same cycle and forces both statPullDn bits to 0 one cycle later. The filter counters keep running, so a fault that has already matured is reported again one cycle after the supply recovers.
- R6: inReq[c]=1 with olOnFlag[c]=1 keeps gateEn[c] at 1 and sets statPullDn[c] after OLON_DLY_US ticks. With inReq[c]=0 that flag never pulls status low.
- R7: ilimFlag[c] alone leaves gateEn[c] at 1 and statPullDn[c] at 0. While ilimFlag[c] is high, the on-state open-load window does not advance.
- R8: inReq[c]=0 with voutHiFlag[c]=1 sets statPullDn[c] after OLOFF_DLY_US ticks. With inReq[c]=1 that flag never pulls status low.
- R9: A fault condition that drops for even one cycle before its window completes restarts its count and gives no status change.
- R10: Channel 0 and channel 1 have separate latches, counters and outputs; a fault on one never changes the other's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inReq | input | 2 | Per-channel on request |
| otFlag | input | 2 | Junction above shutdown temperature |
| trFlag | input | 2 | Junction at or below restart temperature |
| ilimFlag | input | 2 | Current limiter engaged |
| olOnFlag | input | 2 | Load current under on-state open-load threshold |
| voutHiFlag | input | 2 | Output voltage over off-state threshold |
| uvFlag | input | 1 | Shared supply undervoltage |
| ovFlag | input | 1 | Shared supply overvoltage |
| gateEn | output | 2 | Per-channel gate enable |
| statPullDn | output | 2 | Per-channel open-drain status pull-down request (1 = pin low) |

## Verification
Two functions can act in the same cycle: a supply fault masking the status, and a filter window that has already matured. Both pull on the one status bit. The bench lets the off-state open-load window mature first and then raises overvoltage, and after that undervoltage. It expects the pull-down to drop one cycle later and to come back one cycle after the supply recovers. Thermal shutdown and request toggling also overlap, so the bench flips the request while the latch holds and judges the status polarity after each flip.

// File: rtl/hsd_diag_pkg.sv
package hsd_diag_pkg;
  localparam int CH_N = 2;

  typedef struct packed {
    logic            tick;
    logic            supplyOk;
    logic [CH_N-1:0] thermLatch;
  } ctlStrobe_t;
endpackage

// File: rtl/hsd_diag_filter.sv
module hsd_diag_filter #(
  parameter int LIM = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic cond,
  output logic done
);
  localparam int CW = $clog2(LIM + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LIM);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cnt <= '0;
    else if (!cond)                  cnt <= '0;
    else if (tick && cnt != CNT_LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == CNT_LAST);
endmodule

// File: rtl/hsd_diag_ctrl.sv
module hsd_diag_ctrl
  import hsd_diag_pkg::*;
#(
  parameter int CLK_PER_US = 50
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH_N-1:0] otFlag,
  input  logic [CH_N-1:0] trFlag,
  input  logic            uvFlag,
  input  logic            ovFlag,
  output ctlStrobe_t      strobe
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0]   preCnt;
  logic [CH_N-1:0] latchQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  preCnt <= '0;
    else if (preCnt == PRE_LAST) preCnt <= '0;
    else                        preCnt <= preCnt + 1'b1;
  end

  for (genvar c = 0; c < CH_N; c++) begin : g_latch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          latchQ[c] <= 1'b0;
      else if (otFlag[c]) latchQ[c] <= 1'b1;
      else if (trFlag[c]) latchQ[c] <= 1'b0;
    end
  end

  always_comb begin
    strobe.tick       = (preCnt == PRE_LAST);
    strobe.supplyOk   = ~(uvFlag | ovFlag);
    strobe.thermLatch = latchQ;
  end
endmodule

// File: rtl/hsd_diag_dpath.sv
module hsd_diag_dpath
  import hsd_diag_pkg::*;
#(
  parameter int OVL_DLY_US   = 20,
  parameter int OLON_DLY_US  = 200,
  parameter int OLOFF_DLY_US = 1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [CH_N-1:0] inReq,
  input  logic [CH_N-1:0] ilimFlag,
  input  logic [CH_N-1:0] olOnFlag,
  input  logic [CH_N-1:0] voutHiFlag,
  output logic [CH_N-1:0] gateEn,
  output logic [CH_N-1:0] statPullDn
);
  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    logic thermDone, olOnDone, olOffDone;
    logic olOnCond, olOffCond, statNext;

    assign olOnCond  = inReq[c] & olOnFlag[c] & ~ilimFlag[c] & ~strobe.thermLatch[c];
    assign olOffCond = ~inReq[c] & voutHiFlag[c];

    hsd_diag_filter #(.LIM(OVL_DLY_US)) u_therm (
      .clk(clk), .rstN(rstN), .tick(strobe.tick),
      .cond(strobe.thermLatch[c]), .done(thermDone));

    hsd_diag_filter #(.LIM(OLON_DLY_US)) u_olOn (
      .clk(clk), .rstN(rstN), .tick(strobe.tick),
      .cond(olOnCond), .done(olOnDone));

    hsd_diag_filter #(.LIM(OLOFF_DLY_US)) u_olOff (
      .clk(clk), .rstN(rstN), .tick(strobe.tick),
      .cond(olOffCond), .done(olOffDone));

    assign statNext = strobe.supplyOk &
                      ((inReq[c] & (thermDone | olOnDone)) | (~inReq[c] & olOffDone));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statPullDn[c] <= 1'b0;
      else       statPullDn[c] <= statNext;
    end

    assign gateEn[c] = inReq[c] & ~strobe.thermLatch[c] & strobe.supplyOk;
  end
endmodule

// File: rtl/hsd_diag.sv
module hsd_diag
  import hsd_diag_pkg::*;
#(
  parameter int CLK_PER_US   = 50,
  parameter int OVL_DLY_US   = 20,
  parameter int OLON_DLY_US  = 200,
  parameter int OLOFF_DLY_US = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] inReq,
  input  logic [1:0] otFlag,
  input  logic [1:0] trFlag,
  input  logic [1:0] ilimFlag,
  input  logic [1:0] olOnFlag,
  input  logic [1:0] voutHiFlag,
  input  logic       uvFlag,
  input  logic       ovFlag,
  output logic [1:0] gateEn,
  output logic [1:0] statPullDn
);
  ctlStrobe_t strobe;

  hsd_diag_ctrl #(.CLK_PER_US(CLK_PER_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .otFlag(otFlag), .trFlag(trFlag),
    .uvFlag(uvFlag), .ovFlag(ovFlag), .strobe(strobe));

  hsd_diag_dpath #(
    .OVL_DLY_US(OVL_DLY_US), .OLON_DLY_US(OLON_DLY_US), .OLOFF_DLY_US(OLOFF_DLY_US)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inReq(inReq),
    .ilimFlag(ilimFlag), .olOnFlag(olOnFlag), .voutHiFlag(voutHiFlag),
    .gateEn(gateEn), .statPullDn(statPullDn));
endmodule

// File: rtl/hsd_diag_chk.sv
module hsd_diag_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] inReq,
  input logic [1:0] otFlag,
  input logic       uvFlag,
  input logic       ovFlag,
  input logic [1:0] gateEn,
  input logic [1:0] statPullDn
);
  for (genvar c = 0; c < 2; c++) begin : g_chk
    p_gate_needs_req_r1: assert property (@(posedge clk) disable iff (!rstN)
      gateEn[c] |-> inReq[c]);

    p_ot_gate_off_r2: assert property (@(posedge clk) disable iff (!rstN)
      otFlag[c] |=> !gateEn[c]);

    p_supply_gate_off_r5: assert property (@(posedge clk) disable iff (!rstN)
      (uvFlag || ovFlag) |-> !gateEn[c]);

    p_supply_stat_off_r5: assert property (@(posedge clk) disable iff (!rstN)
      (uvFlag || ovFlag) |=> !statPullDn[c]);
  end
endmodule

bind hsd_diag hsd_diag_chk u_chk (
  .clk(clk), .rstN(rstN), .inReq(inReq), .otFlag(otFlag),
  .uvFlag(uvFlag), .ovFlag(ovFlag), .gateEn(gateEn), .statPullDn(statPullDn));

// File: tb/hsd_diag_test.sv
module hsd_diag_test;
  localparam int P     = 4;
  localparam int OVL   = 3;
  localparam int OLON  = 5;
  localparam int OLOFF = 7;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] inReq, otFlag, trFlag, ilimFlag, olOnFlag, voutHiFlag;
  logic uvFlag, ovFlag;
  logic [1:0] gateEn, statPullDn;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hsd_diag #(.CLK_PER_US(P), .OVL_DLY_US(OVL), .OLON_DLY_US(OLON), .OLOFF_DLY_US(OLOFF)) uut (
    .clk(clk), .rstN(rstN), .inReq(inReq), .otFlag(otFlag), .trFlag(trFlag),
    .ilimFlag(ilimFlag), .olOnFlag(olOnFlag), .voutHiFlag(voutHiFlag),
    .uvFlag(uvFlag), .ovFlag(ovFlag), .gateEn(gateEn), .statPullDn(statPullDn));

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clearAll();
    inReq = '0; otFlag = '0; trFlag = '0; ilimFlag = '0;
    olOnFlag = '0; voutHiFlag = '0; uvFlag = 1'b0; ovFlag = 1'b0;
  endtask

  task automatic settle();
    clearAll();
    trFlag = 2'b11;
    waitCyc(3);
    trFlag = '0;
    waitCyc(3);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    clearAll();
    rstN = 1'b0;
    waitCyc(3);
    check("reset gate0", gateEn[0], 1'b0);
    check("reset stat0", statPullDn[0], 1'b0);
    check("reset stat1", statPullDn[1], 1'b0);
    rstN = 1'b1;
    waitCyc(2);

    // R1 / R5 sweep: request levels against supply flags
    for (int i = 0; i < 16; i++) begin
      inReq = i[1:0]; uvFlag = i[2]; ovFlag = i[3];
      waitCyc(2);
      for (int c = 0; c < 2; c++) begin
        check("R1/R5 sweep gate", gateEn[c], inReq[c] & ~(uvFlag | ovFlag));
        check("R1/R5 sweep stat", statPullDn[c], 1'b0);
      end
    end
    settle();

    // R6: on-state open load
    inReq = 2'b11; olOnFlag = 2'b01;
    waitCyc((OLON - 1) * P - 1);
    check("R6 early stat0", statPullDn[0], 1'b0);
    check("R6 gate stays on", gateEn[0], 1'b1);
    waitCyc(8);
    check("R6 late stat0", statPullDn[0], 1'b1);
    check("R10 ch1 untouched", statPullDn[1], 1'b0);
    check("R10 ch1 gate", gateEn[1], 1'b1);
    inReq[0] = 1'b0;
    waitCyc(OLON * P + 4);
    check("R6 low request no report", statPullDn[0], 1'b0);
    settle();

    // R9: glitch restarts the window
    inReq = 2'b01; olOnFlag = 2'b01;
    waitCyc((OLON - 2) * P);
    olOnFlag = 2'b00;
    waitCyc(1);
    olOnFlag = 2'b01;
    waitCyc((OLON - 2) * P);
    check("R9 glitch no report", statPullDn[0], 1'b0);
    settle();

    // R7: current limit alone and its effect on open-load counting
    inReq = 2'b01; ilimFlag = 2'b01;
    waitCyc(OLON * P + 6);
    check("R7 ilim gate on", gateEn[0], 1'b1);
    check("R7 ilim stat released", statPullDn[0], 1'b0);
    olOnFlag = 2'b01;
    waitCyc(OLON * P + 6);
    check("R7 ilim suppresses open load", statPullDn[0], 1'b0);
    settle();

    // R8: off-state open load / short to supply
    inReq = 2'b00; voutHiFlag = 2'b01;
    waitCyc((OLOFF - 1) * P - 1);
    check("R8 early stat0", statPullDn[0], 1'b0);
    waitCyc(8);
    check("R8 late stat0", statPullDn[0], 1'b1);
    // R5: supply fault masks matured report, recovers without recount
    ovFlag = 1'b1;
    waitCyc(2);
    check("R5 ov masks stat", statPullDn[0], 1'b0);
    ovFlag = 1'b0; uvFlag = 1'b1;
    waitCyc(2);
    check("R5 uv masks stat", statPullDn[0], 1'b0);
    uvFlag = 1'b0;
    waitCyc(2);
    check("R5 report back after recovery", statPullDn[0], 1'b1);
    inReq[0] = 1'b1;
    waitCyc(2);
    check("R8 high request releases", statPullDn[0], 1'b0);
    waitCyc(OLOFF * P + 4);
    check("R8 high request no report", statPullDn[0], 1'b0);
    settle();

    // R2 / R3 / R4: thermal shutdown, status polarity, restart
    inReq = 2'b11; otFlag = 2'b01;
    waitCyc(1);
    check("R2 gate off after ot", gateEn[0], 1'b0);
    check("R10 ch1 gate on", gateEn[1], 1'b1);
    otFlag = 2'b00;
    waitCyc(3);
    check("R2 latch holds gate off", gateEn[0], 1'b0);
    waitCyc((OVL - 1) * P - 1 - 4);
    check("R4 early stat0", statPullDn[0], 1'b0);
    waitCyc(P + 6);
    check("R4 stat low with request high", statPullDn[0], 1'b1);
    check("R10 ch1 stat", statPullDn[1], 1'b0);
    inReq[0] = 1'b0;
    waitCyc(2);
    check("R4 stat released with request low", statPullDn[0], 1'b0);
    check("R2 gate still off", gateEn[0], 1'b0);
    inReq[0] = 1'b1;
    waitCyc(2);
    check("R4 stat low again", statPullDn[0], 1'b1);
    trFlag = 2'b01;
    waitCyc(1);
    check("R3 gate restarts", gateEn[0], 1'b1);
    trFlag = 2'b00;
    waitCyc(3);
    check("R3 stat released after restart", statPullDn[0], 1'b0);
    check("R3 gate follows request", gateEn[0], 1'b1);
    inReq[0] = 1'b0;
    waitCyc(1);
    check("R3 gate follows low request", gateEn[0], 1'b0);

    waitCyc(4);
    finish();
  end
endmodule